// File: doc/BRIEF.md
# Daisy-Chainable Serial Wiper Register

This block is the digital front end of a 256-tap digital potentiometer. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data input. While the select is low, each rising serial-clock edge moves one data bit, most significant bit first, into an 8-bit shift register. When the select returns high, the shift register is copied into the wiper register. The wiper register drives the tap decoder of the resistor ladder. With code D the wiper-to-B resistance is D/256 of the end-to-end resistance plus the wiper switch resistance. Code 0x00 puts the wiper on terminal B.

The top bit of the shift register leaves the block on an open-drain data output. A bit of 0 pulls the line low. A bit of 1 releases it, and an external pull-up raises it. Because the output carries the bits received in the previous frame, several devices can share select and clock in a chain. In a chain of two, 16 clocks go under one select-low window, and the first 8 bits end up in the far device. Frames longer than the chain simply push the oldest bits out of the top.

All three serial inputs are sampled by a faster system clock through synchronizers and edge detectors. The serial clock may run at up to one quarter of the system clock rate.

Top module: `serial_wiper_reg`

## Requirements
- R1: After reset the wiper code is midscale, 0x80. The data output is released (`sdo_pull_low` = 0), because the shift register also starts at 0x80.
- R2: While select is low, each rising serial-clock edge shifts one data bit into bit 0 of the shift register. After 8 clocks the first bit sent is bit 7 (MSB-first order).
- R3: The wiper code changes only on a rising edge of select. During a frame it holds its previous value.
- R4: When more than 8 bits are clocked into one device in a frame, only the last 8 bits received are loaded. The earlier leading bits are discarded.
- R5: Serial-clock edges while select is high change neither the shift register nor the data output, whatever the data input does.
- R6: `sdo_pull_low` is 1 exactly when the current bit 7 of the shift register is 0. It changes only after a rising serial-clock edge during a frame.
- R7: With two devices chained through the open-drain output and a pull-up, a 16-bit frame loads the first 8 bits into the far device and the last 8 bits into the near device.
- R8: A select high-low-high with no serial clocks in between reloads the unchanged shift register, so the wiper code stays the same.
- R9: The end codes 0x00 and 0xFF are both loaded exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low serial select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data input |
| wiper_code | output | 8 | Wiper tap code for the resistor ladder |
| sdo_pull_low | output | 1 | Open-drain data-out enable; 1 pulls the line low |

## Verification
A corrupted shift register is not visible on the wiper until the next select rising edge. It is visible on the data output right away, and in a chain it appears one frame later as a wrong code in the far device. The bench therefore checks both devices' codes after every frame and both data outputs between frames. A wrong update condition shows up within a few system cycles as a wiper change in the middle of a frame, or as a change after a zero-clock select pulse. Overlong frames and clock pulses with select high test whether bits are kept or dropped at the right edges.

// File: rtl/serial_wiper_reg.sv
module serial_wiper_reg #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] wiper_code,
  output logic              sdo_pull_low
);

  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

  logic [SYNC_STAGES-1:0] cs_sync, clk_sync, dat_sync;
  logic                   cs_last, sclk_last;
  logic [CODE_W-1:0]      shreg;

  wire cs_s   = cs_sync[SYNC_STAGES-1];
  wire sclk_s = clk_sync[SYNC_STAGES-1];
  wire sdi_s  = dat_sync[SYNC_STAGES-1];

  wire sclk_rise = sclk_s & ~sclk_last;
  wire cs_rise   = cs_s & ~cs_last;
  wire do_shift  = sclk_rise & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= '1;
      clk_sync  <= '0;
      dat_sync  <= '0;
      cs_last   <= 1'b1;
      sclk_last <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      clk_sync  <= {clk_sync[SYNC_STAGES-2:0], sclk};
      dat_sync  <= {dat_sync[SYNC_STAGES-2:0], sdi};
      cs_last   <= cs_s;
      sclk_last <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= MIDSCALE;
    else if (do_shift) shreg <= {shreg[CODE_W-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wiper_code <= MIDSCALE;
    else if (cs_rise) wiper_code <= shreg;
  end

  assign sdo_pull_low = ~shreg[CODE_W-1];

  // R3
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(wiper_code));

  // R5
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(shreg));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> shreg[0] == $past(sdi_s));

  // R6
  sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_shift |=> $stable(sdo_pull_low));

endmodule

// File: tb/serial_wiper_reg_tb_top.sv
module serial_wiper_reg_tb_top;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [W-1:0] code_near, code_far;
  logic pull_near, pull_far;
  wire  link = pull_near ? 1'b0 : 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [2*W-1:0] chain_m;

  always #4 clk = ~clk;

  serial_wiper_reg #(.CODE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .wiper_code(code_near), .sdo_pull_low(pull_near));

  serial_wiper_reg #(.CODE_W(W)) far_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(link),
    .wiper_code(code_far), .sdo_pull_low(pull_far));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    sdi = b;
    wait_cyc(4);
    sclk = 1'b1;
    if (!cs_n) chain_m = {chain_m[2*W-2:0], b};
    wait_cyc(4);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    wait_cyc(4);
    for (int i = n - 1; i >= 0; i--) clock_bit(bits[i]);
    wait_cyc(4);
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic check_chain(input string req);
    check({req, " near"}, {8'h0, code_near}, {8'h0, chain_m[W-1:0]});
    check({req, " far"}, {8'h0, code_far}, {8'h0, chain_m[2*W-1:W]});
    check({req, " R6 near sdo"}, {15'h0, pull_near}, {15'h0, ~chain_m[W-1]});
    check({req, " R6 far sdo"}, {15'h0, pull_far}, {15'h0, ~chain_m[2*W-1]});
  endtask

  task automatic t_reset;
    check("R1 near", {8'h0, code_near}, 16'h0080);
    check("R1 far", {8'h0, code_far}, 16'h0080);
    check("R1 sdo", {15'h0, pull_near}, 16'h0000);
  endtask

  task automatic t_chain16;
    send(32'h0000_3CA5, 16);
    check("R7 far first byte", {8'h0, code_far}, 16'h003C);
    check("R7 near last byte", {8'h0, code_near}, 16'h00A5);
    check_chain("R2 R7");
  endtask

  task automatic t_midframe;
    cs_n = 1'b0;
    wait_cyc(4);
    for (int i = 15; i >= 8; i--) clock_bit(1'(16'h5E71 >> i));
    wait_cyc(6);
    check("R3 near held", {8'h0, code_near}, 16'h00A5);
    check("R3 far held", {8'h0, code_far}, 16'h003C);
    for (int i = 7; i >= 0; i--) clock_bit(1'(16'h5E71 >> i));
    wait_cyc(4);
    cs_n = 1'b1;
    wait_cyc(8);
    check_chain("R3 after");
  endtask

  task automatic t_overlong;
    send(32'h0001_5A3C, 21);
    check("R4 far", {8'h0, code_far}, 16'h005A);
    check("R4 near", {8'h0, code_near}, 16'h003C);
    check_chain("R4");
  endtask

  task automatic t_idle_clocks;
    logic p0;
    p0 = pull_near;
    for (int i = 0; i < 6; i++) clock_bit(i[0]);
    wait_cyc(6);
    check("R5 sdo", {15'h0, pull_near}, {15'h0, p0});
    cs_n = 1'b0;
    wait_cyc(8);
    cs_n = 1'b1;
    wait_cyc(8);
    check_chain("R5 R8");
  endtask

  task automatic t_ends;
    send(32'h0000_FF00, 16);
    check("R9 far 0xFF", {8'h0, code_far}, 16'h00FF);
    check("R9 near 0x00", {8'h0, code_near}, 16'h0000);
    check("R6 near pulls", {15'h0, pull_near}, 16'h0001);
    send(32'h0000_00FF, 16);
    check_chain("R9 swap");
  endtask

  initial begin
    chain_m = 16'h8080;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_chain16();
    t_midframe();
    t_overlong();
    t_idle_clocks();
    t_ends();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule